// File: doc/BRIEF.md
# Byte-Serial Debug Slave Port

This block is the chip-side end of a synchronous serial link used by an external debug host. The host drives a serial clock and a data line. On every rising edge of that clock the port takes one bit, and it groups eight bits into a byte, most significant bit first. Each completed byte is handed to the core on a parallel bus together with a one-cycle valid strobe. In the other direction, the core loads a response byte. The port moves that byte onto the serial output one bit per host clock, so that each bit is steady when the host samples it on its next rising edge.

The host clock is not related to the system clock and runs at no more than half its rate. The port brings the host clock and the data line into the system domain through a short flop chain and finds rising edges on the synchronised copy. An active-low busy output tells the host to wait. It stays asserted from reset until the core says it is ready, and it is asserted again whenever a received byte has not yet been taken by the core. A byte that completes while the previous one is still unclaimed raises a sticky overrun flag.

Top module: `dbg_serial_port`

## Requirements
- R1: While and right after synchronous reset, host_busy_n_o is 0, rx_valid_o is 0, rx_overrun_o is 0 and host_dout_o is 0.
- R2: host_busy_n_o stays 0 after reset until core_ready_i has been seen high for at least one cycle. From then on readiness is remembered, and busy depends only on pending bytes.
- R3: Received bytes are assembled most significant bit first. Each bit is the level of host_din_i at a rising edge of host_clk_i. rx_byte_o shows the byte after the eighth rising edge and holds it until the next byte completes.
- R4: Every eighth host rising edge produces exactly one rx_valid_o pulse, one system cycle long.
- R5: From the cycle rx_valid_o rises until the cycle after rx_ack_i is high, host_busy_n_o is 0. After the acknowledge it returns to 1.
- R6: If a byte completes while the previous byte is still unacknowledged, rx_overrun_o becomes 1 and rx_byte_o takes the new byte. The flag stays set until reset, even after an acknowledge.
- R7: A byte loaded with tx_load_i appears on host_dout_o most significant bit first. The first bit is shown from the cycle after the load. Each later bit is driven after the host rising edge that sampled the one before. After eight rising edges host_dout_o is 0.
- R8: A reset in the middle of a byte clears the bit counter and both shift registers. The next eight host rising edges form a whole new byte, and no stale transmit bits are sent.
- R9: Changes on host_din_i while host_clk_i does not rise have no effect. No byte is counted, and the next byte is received intact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| host_clk_i | input | 1 | Serial clock from the debug host, at most half the system rate |
| host_din_i | input | 1 | Serial data from the host |
| host_dout_o | output | 1 | Serial data to the host |
| host_busy_n_o | output | 1 | Active-low busy, holds off the host |
| core_ready_i | input | 1 | Core signals it can handle transactions |
| rx_byte_o | output | 8 | Last received byte |
| rx_valid_o | output | 1 | One-cycle strobe for a new received byte |
| rx_ack_i | input | 1 | Core has consumed the received byte |
| rx_overrun_o | output | 1 | Sticky: a byte arrived while one was pending |
| tx_byte_i | input | 8 | Response byte from the core |
| tx_load_i | input | 1 | Load tx_byte_i into the transmit shifter |

## Verification
The checks assume the host holds each level of host_clk_i for at least one system cycle. They also assume host_din_i is steady from before a host rising edge until that edge has passed the synchroniser. The bench therefore keeps every clock phase three system cycles long and changes data only while the clock is low. They further assume the core never acknowledges in the same cycle a byte completes, and loads a transmit byte only between bytes. The bench issues acknowledges and loads only when no host edge is in flight.

// File: rtl/dsp_pkg.sv
package dsp_pkg;
    localparam int unsigned DSP_BYTE_W = 8;

    // one synchronised host bit event
    typedef struct packed {
        logic rise;
        logic data;
    } dsp_bit_evt_t;
endpackage

// File: rtl/dsp_sync.sv
module dsp_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  host_clk_i,
    input  logic                  host_din_i,
    output dsp_pkg::dsp_bit_evt_t evt_o
);
    localparam int unsigned TOP = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] ck;
        logic [STAGES-1:0] dt;
        logic              ck_last;
    } sync_st_t;

    sync_st_t q, d;

    always_comb begin
        d         = q;
        d.ck[0]   = host_clk_i;
        d.dt[0]   = host_din_i;
        d.ck_last = q.ck[TOP];
    end

    // data travels through the same depth as the clock so both line up
    for (genvar g = 1; g < STAGES; g++) begin : g_chain
        always_ff @(posedge clk) begin
            if (rst) begin
                q.ck[g] <= 1'b0;
                q.dt[g] <= 1'b0;
            end else begin
                q.ck[g] <= q.ck[g-1];
                q.dt[g] <= q.dt[g-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.ck[0]   <= 1'b0;
            q.dt[0]   <= 1'b0;
            q.ck_last <= 1'b0;
        end else begin
            q.ck[0]   <= d.ck[0];
            q.dt[0]   <= d.dt[0];
            q.ck_last <= d.ck_last;
        end
    end

    assign evt_o.rise = q.ck[TOP] & ~q.ck_last;
    assign evt_o.data = q.dt[TOP];

    // R9: one host rising edge gives a single-cycle event
    a_r9_rise_single: assert property (@(posedge clk) disable iff (rst)
        evt_o.rise |=> !evt_o.rise);
endmodule

// File: rtl/dsp_rx.sv
module dsp_rx #(
    parameter int unsigned DATA_W = dsp_pkg::DSP_BYTE_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  dsp_pkg::dsp_bit_evt_t evt_i,
    input  logic                  ack_i,
    output logic [DATA_W-1:0]     data_o,
    output logic                  valid_o,
    output logic                  pending_o,
    output logic                  overrun_o
);
    localparam int unsigned CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    typedef struct packed {
        logic [DATA_W-1:0] shift;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] data;
        logic              valid;
        logic              pending;
        logic              overrun;
    } rx_st_t;

    rx_st_t q, d;

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        if (ack_i) d.pending = 1'b0;
        if (evt_i.rise) begin
            d.shift = {q.shift[DATA_W-2:0], evt_i.data};
            if (q.cnt == LAST) begin
                d.cnt     = '0;
                d.data    = {q.shift[DATA_W-2:0], evt_i.data};
                d.valid   = 1'b1;
                d.pending = 1'b1;
                if (q.pending && !ack_i) d.overrun = 1'b1;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign data_o    = q.data;
    assign valid_o   = q.valid;
    assign pending_o = q.pending;
    assign overrun_o = q.overrun;

    // R4: strobe lasts one cycle
    a_r4_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);
    // R3: bit counter moves only on a host rising edge
    a_r3_cnt_hold: assert property (@(posedge clk) disable iff (rst)
        !evt_i.rise |=> $stable(q.cnt));
    // R6: overrun is sticky
    a_r6_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
        overrun_o |=> overrun_o);
endmodule

// File: rtl/dsp_tx.sv
module dsp_tx #(
    parameter int unsigned DATA_W = dsp_pkg::DSP_BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rise_i,
    input  logic              load_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              sdo_o
);
    typedef struct packed {
        logic [DATA_W-1:0] shift;
    } tx_st_t;

    tx_st_t q, d;

    always_comb begin
        d = q;
        if (load_i)      d.shift = data_i;
        else if (rise_i) d.shift = {q.shift[DATA_W-2:0], 1'b0};
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign sdo_o = q.shift[DATA_W-1];

    // R7: output bit changes only on a load or after a host rising edge
    a_r7_sdo_hold: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !rise_i) |=> $stable(sdo_o));
endmodule

// File: rtl/dbg_serial_port.sv
module dbg_serial_port #(
    parameter int unsigned DATA_W      = dsp_pkg::DSP_BYTE_W,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_clk_i,
    input  logic              host_din_i,
    output logic              host_dout_o,
    output logic              host_busy_n_o,
    input  logic              core_ready_i,
    output logic [DATA_W-1:0] rx_byte_o,
    output logic              rx_valid_o,
    input  logic              rx_ack_i,
    output logic              rx_overrun_o,
    input  logic [DATA_W-1:0] tx_byte_i,
    input  logic              tx_load_i
);
    typedef struct packed {
        logic ready;
    } top_st_t;

    top_st_t q, d;
    dsp_pkg::dsp_bit_evt_t evt;
    logic pending;

    dsp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .host_clk_i (host_clk_i),
        .host_din_i (host_din_i),
        .evt_o      (evt)
    );

    dsp_rx #(.DATA_W(DATA_W)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .evt_i     (evt),
        .ack_i     (rx_ack_i),
        .data_o    (rx_byte_o),
        .valid_o   (rx_valid_o),
        .pending_o (pending),
        .overrun_o (rx_overrun_o)
    );

    dsp_tx #(.DATA_W(DATA_W)) u_tx (
        .clk    (clk),
        .rst    (rst),
        .rise_i (evt.rise),
        .load_i (tx_load_i),
        .data_i (tx_byte_i),
        .sdo_o  (host_dout_o)
    );

    always_comb begin
        d       = q;
        d.ready = q.ready | core_ready_i;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign host_busy_n_o = q.ready & ~pending;

    // R5: a fresh byte always holds the host off
    a_r5_busy_on_valid: assert property (@(posedge clk) disable iff (rst)
        rx_valid_o |-> !host_busy_n_o);
    // R2: readiness, once seen, is kept
    a_r2_ready_sticky: assert property (@(posedge clk) disable iff (rst)
        q.ready |=> q.ready);
endmodule

// File: tb/dbg_serial_port_test.sv
module dbg_serial_port_test;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst, host_clk, host_din, host_dout, busy_n;
    logic       core_ready, rx_valid, rx_ack, overrun, tx_load;
    logic [7:0] rx_byte, tx_byte;

    int total = 0;
    int bad   = 0;
    int vcount = 0;
    bit done  = 1'b0;

    dbg_serial_port uut (
        .clk           (clk),
        .rst           (rst),
        .host_clk_i    (host_clk),
        .host_din_i    (host_din),
        .host_dout_o   (host_dout),
        .host_busy_n_o (busy_n),
        .core_ready_i  (core_ready),
        .rx_byte_o     (rx_byte),
        .rx_valid_o    (rx_valid),
        .rx_ack_i      (rx_ack),
        .rx_overrun_o  (overrun),
        .tx_byte_i     (tx_byte),
        .tx_load_i     (tx_load)
    );

    // upper byte: sent by host, lower byte: loaded by core
    localparam logic [15:0] VEC [6] = '{16'hA53C, 16'h00FF, 16'hFF00,
                                        16'h817E, 16'h5AC3, 16'h0180};

    always @(negedge clk) if (rx_valid) vcount++;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic load_tx(input logic [7:0] b);
        tx_byte = b;
        tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
        @(negedge clk);
    endtask

    task automatic ack();
        rx_ack = 1'b1;
        @(negedge clk);
        rx_ack = 1'b0;
        @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] b, output logic [7:0] got);
        for (int i = 7; i >= 0; i--) begin
            host_din = b[i];
            host_clk = 1'b0;
            repeat (3) @(negedge clk);
            got[i]   = host_dout;
            host_clk = 1'b1;
            repeat (3) @(negedge clk);
        end
        host_clk = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic make_ready();
        core_ready = 1'b1;
        @(negedge clk);
        core_ready = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        logic [7:0] got;
        int v0;
        rst = 1'b1; host_clk = 1'b0; host_din = 1'b0; core_ready = 1'b0;
        rx_ack = 1'b0; tx_load = 1'b0; tx_byte = '0;
        repeat (3) @(negedge clk);
        chk("R1 busy_n", busy_n, 0);
        chk("R1 rx_valid", rx_valid, 0);
        chk("R1 overrun", overrun, 0);
        chk("R1 dout", host_dout, 0);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        chk("R2 busy before ready", busy_n, 0);
        make_ready();
        chk("R2 busy after ready", busy_n, 1);

        // table walk: full-duplex bytes
        for (int k = 0; k < 6; k++) begin
            load_tx(VEC[k][7:0]);
            v0 = vcount;
            xfer(VEC[k][15:8], got);
            chk("R7 tx byte", got, VEC[k][7:0]);
            chk("R3 rx byte", rx_byte, VEC[k][15:8]);
            chk("R4 one strobe", vcount - v0, 1);
            chk("R5 busy while pending", busy_n, 0);
            chk("R7 dout drained", host_dout, 0);
            ack();
            chk("R5 busy after ack", busy_n, 1);
            chk("R6 no overrun", overrun, 0);
        end

        // overrun
        xfer(8'h12, got);
        chk("R6 first not flagged", overrun, 0);
        xfer(8'h34, got);
        chk("R6 overrun set", overrun, 1);
        chk("R6 newest byte kept", rx_byte, 8'h34);
        ack();
        chk("R6 overrun sticky", overrun, 1);

        // reset mid-byte with a transmit byte loaded
        load_tx(8'hF0);
        for (int i = 0; i < 3; i++) begin
            host_din = 1'b1; host_clk = 1'b0;
            repeat (3) @(negedge clk);
            host_clk = 1'b1;
            repeat (3) @(negedge clk);
        end
        host_clk = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 overrun cleared", overrun, 0);
        chk("R1 busy after reset", busy_n, 0);
        make_ready();

        // data toggles without host edges
        v0 = vcount;
        for (int i = 0; i < 10; i++) begin
            host_din = ~host_din;
            @(negedge clk);
        end
        chk("R9 no strobe without edge", vcount - v0, 0);
        xfer(8'hC6, got);
        chk("R8 fresh byte after reset", rx_byte, 8'hC6);
        chk("R9 one strobe", vcount - v0, 1);
        chk("R8 tx shifter cleared", got, 8'h00);
        chk("R8 no overrun", overrun, 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule